// File: doc/BRIEF.md
# Mobile SDRAM Command Controller

This block sits between a simple host request port and a four-bank single-data-rate SDRAM with a 16-bit data bus. The host presents one word request at a time. Each request carries a flat word address, a read/write flag, write data and byte enables, and uses a valid/ready handshake. Read data comes back as a burst of words, each marked by a response-valid strobe.

After reset the controller waits a programmable settling time. It then runs the start-up sequence: it closes every bank, issues two refresh cycles, and loads the mode word and the extended mode word. The mode word selects the CAS latency, a sequential read burst, and write bursts of one word. The CAS latency comes from a configuration input and is captured at the mode-load step.

Every access uses a closed-page pattern: open the row, issue the column command, then precharge the bank. Counters hold each command back until its timing parameter is met. A free-running interval timer raises a refresh request. That request wins over new host traffic and is only served when no row is open.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: The flat address is split as column = bits [9:0], row = bits [22:10] and bank = bits [24:23]. Row and bank go out with the activate command, and the column goes out with the read or write command.
- R2: After reset only NOP appears on the command pins for at least INIT_CYC cycles, and req_ready stays low. The start-up commands then follow in this exact order: precharge with address bit 10 high, refresh, refresh, mode load with bank 00, and mode load with bank 10.
- R3: The mode word has bits [2:0] = log2(BURST_LEN), bit 3 = 0 (sequential), bits [6:4] = CAS latency, bit 9 = 1 (single-word writes), and all other bits 0. The extended mode word carries EMRS_VAL.
- R4: The command pins {cs_n, ras_n, cas_n, we_n} use these codes: NOP 0111, activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode load 0000. No other code is ever driven.
- R5: A read or write comes at least T_RCD cycles after the activate that opened its row.
- R6: An activate or refresh comes at least T_RP cycles after a precharge. Two activates are at least T_RC cycles apart. A refresh is followed by at least T_RC cycles with no other command.
- R7: A precharge comes at least T_WR cycles after a write.
- R8: A write command moves exactly one word. The data enable is high only in the write cycle, and sd_dqm equals the inverted req_be, with bit 0 masking the low byte. A write with req_be = 00 leaves memory unchanged.
- R9: Each read request returns BURST_LEN words in consecutive cycles. The column sequence wraps within the aligned burst block.
- R10: With read command cycle n and effective latency CL, the first word appears on rsp_valid in cycle n+CL+1. CL is cfg_cas_lat sampled at the mode-load step, and a value of 0 is treated as 3. Changes to cfg_cas_lat after that step have no effect until the next reset.
- R11: Refresh commands come at most REF_CYC plus one access length apart. A refresh is issued only when all banks are closed, and a pending refresh holds off new host requests.
- R12: Each accepted request ends by precharging its bank. After an acceptance, req_ready drops for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cas_lat | input | 2 | CAS latency to program (1, 2, 3; 0 means 3) |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller accepts the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (25) | Flat word address |
| req_wdata | input | DATA_W (16) | Write data |
| req_be | input | DQM_W (2) | Byte enables, bit 0 = low byte |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W (16) | Read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W (2) | Bank address |
| sd_addr | output | ROW_W (13) | Multiplexed row/column address |
| sd_dqm | output | DQM_W (2) | Byte masks, high = masked |
| sd_dq_out | output | DATA_W (16) | Write data to memory |
| sd_dq_oe | output | 1 | Write data enable |
| sd_dq_in | input | DATA_W (16) | Read data from memory |

## Verification
The bench runs four resets, one for each latency setting including the 0-means-3 case, against a memory model that learns the latency from the mode word. A capture point off by one cycle would return the idle filler pattern or a neighbouring burst word instead of the expected data. Reads that start at columns near the top of a burst block, and the highest flat address, catch a wrong column wrap or a wrong address split. Partial and empty byte-enable writes followed by reads catch an inverted or swapped mask. A short refresh interval forces refreshes to collide with traffic; a controller that refreshed with a row open, or let host requests starve the refresh, trips the open-bank and interval checks.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] SD_NOP = 4'b0111;
    localparam logic [3:0] SD_ACT = 4'b0011;
    localparam logic [3:0] SD_RD  = 4'b0101;
    localparam logic [3:0] SD_WR  = 4'b0100;
    localparam logic [3:0] SD_PRE = 4'b0010;
    localparam logic [3:0] SD_REF = 4'b0001;
    localparam logic [3:0] SD_MRS = 4'b0000;

    localparam int AP_BIT = 10; // auto/all-bank bit on the address pins

    typedef enum logic [2:0] {
        S_PWR   = 3'd0,
        S_IREF1 = 3'd1,
        S_IREF2 = 3'd2,
        S_MODE  = 3'd3,
        S_XMODE = 3'd4,
        S_IDLE  = 3'd5,
        S_COL   = 3'd6,
        S_CLOSE = 3'd7
    } ctl_state_e;
endpackage

// File: rtl/sdc_addr_map.sv
module sdc_addr_map #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    localparam int ADDR_W = BANK_W + ROW_W + COL_W
) (
    input  logic [ADDR_W-1:0] flat_addr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);
    assign col  = flat_addr[COL_W-1:0];
    assign row  = flat_addr[COL_W +: ROW_W];
    assign bank = flat_addr[ADDR_W-1 -: BANK_W];
endmodule

// File: rtl/sdc_rd_pipe.sv
module sdc_rd_pipe #(
    parameter int DATA_W    = 16,
    parameter int BURST_LEN = 4,
    localparam int REM_W = $clog2(BURST_LEN) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue,
    input  logic [1:0]        cas_lat,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    typedef struct packed {
        logic [2:0]        sh;
        logic [REM_W-1:0]  rem;
        logic              vld;
        logic [DATA_W-1:0] dat;
    } pipe_t;

    pipe_t pipe_q, pipe_d;
    logic  tap;

    always_comb begin
        case (cas_lat)
            2'd1:    tap = pipe_q.sh[0];
            2'd2:    tap = pipe_q.sh[1];
            default: tap = pipe_q.sh[2];
        endcase
    end

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.sh  = {pipe_q.sh[1:0], rd_issue};
        pipe_d.vld = 1'b0;
        if (tap) begin
            pipe_d.vld = 1'b1;
            pipe_d.dat = dq_in;
            pipe_d.rem = REM_W'(BURST_LEN - 1);
        end else if (pipe_q.rem != '0) begin
            pipe_d.vld = 1'b1;
            pipe_d.dat = dq_in;
            pipe_d.rem = pipe_q.rem - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign rsp_valid = pipe_q.vld;
    assign rsp_data  = pipe_q.dat;
endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
    import sdc_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int DATA_W    = 16,
    parameter int BURST_LEN = 4,
    parameter int INIT_CYC  = 20000,
    parameter int REF_CYC   = 1560,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RC      = 9,
    parameter int T_WR      = 2,
    parameter int T_MRD     = 2,
    parameter int unsigned EMRS_VAL = 0,
    localparam int ADDR_W = BANK_W + ROW_W + COL_W,
    localparam int DQM_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_cas_lat,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DQM_W-1:0]  req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DATA_W-1:0] sd_dq_in
);
    localparam int M1       = (INIT_CYC > REF_CYC) ? INIT_CYC : REF_CYC;
    localparam int WAIT_MAX = (M1 > T_RC + BURST_LEN) ? M1 : T_RC + BURST_LEN;
    localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
    localparam int RC_W     = $clog2(T_RC + 1);
    localparam int REF_W    = $clog2(REF_CYC + 1);
    localparam logic [2:0] BL_CODE = 3'($clog2(BURST_LEN));

    typedef struct packed {
        ctl_state_e        st;
        logic [WAIT_W-1:0] wt;
        logic [RC_W-1:0]   rc;
        logic [REF_W-1:0]  rcnt;
        logic              rpend;
        logic              live;
        logic [1:0]        cl;
        logic [3:0]        cmd;
        logic [BANK_W-1:0] ba;
        logic [ROW_W-1:0]  a;
        logic [DQM_W-1:0]  dqm;
        logic [DATA_W-1:0] dq;
        logic              oe;
        logic              r_wr;
        logic [BANK_W-1:0] r_ba;
        logic [ROW_W-1:0]  r_row;
        logic [COL_W-1:0]  r_col;
        logic [DATA_W-1:0] r_dat;
        logic [DQM_W-1:0]  r_be;
    } ctl_t;

    ctl_t q, n;

    logic [BANK_W-1:0] map_ba;
    logic [ROW_W-1:0]  map_row;
    logic [COL_W-1:0]  map_col;
    logic [1:0]        cl_sel;
    logic [ROW_W-1:0]  mode_word;

    sdc_addr_map #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) map_i (
        .flat_addr(req_addr), .bank(map_ba), .row(map_row), .col(map_col)
    );

    assign cl_sel = (cfg_cas_lat == 2'd0) ? 2'd3 : cfg_cas_lat;

    always_comb begin
        mode_word      = '0;
        mode_word[2:0] = BL_CODE;
        mode_word[6:4] = {1'b0, cl_sel};
        mode_word[9]   = 1'b1;
    end

    assign req_ready = (q.st == S_IDLE) && (q.wt == '0) && (q.rc == '0) && !q.rpend;

    always_comb begin
        n     = q;
        n.cmd = SD_NOP;
        n.oe  = 1'b0;
        n.dqm = '0;
        if (q.rc != '0) n.rc = q.rc - 1'b1;
        if (q.wt != '0) begin
            n.wt = q.wt - 1'b1;
        end else begin
            case (q.st)
                S_PWR: begin
                    n.cmd = SD_PRE;
                    n.a   = '0;
                    n.a[AP_BIT] = 1'b1;
                    n.wt  = WAIT_W'(T_RP - 1);
                    n.st  = S_IREF1;
                end
                S_IREF1, S_IREF2: begin
                    n.cmd = SD_REF;
                    n.wt  = WAIT_W'(T_RC - 1);
                    n.st  = (q.st == S_IREF1) ? S_IREF2 : S_MODE;
                end
                S_MODE: begin
                    n.cmd = SD_MRS;
                    n.ba  = '0;
                    n.a   = mode_word;
                    n.cl  = cl_sel;
                    n.wt  = WAIT_W'(T_MRD - 1);
                    n.st  = S_XMODE;
                end
                S_XMODE: begin
                    n.cmd  = SD_MRS;
                    n.ba   = BANK_W'(2);
                    n.a    = ROW_W'(EMRS_VAL);
                    n.wt   = WAIT_W'(T_MRD - 1);
                    n.live = 1'b1;
                    n.rcnt = REF_W'(REF_CYC - 1);
                    n.st   = S_IDLE;
                end
                S_IDLE: begin
                    if (q.rpend && q.rc == '0) begin
                        n.cmd   = SD_REF;
                        n.rpend = 1'b0;
                        n.wt    = WAIT_W'(T_RC - 1);
                    end else if (req_valid && req_ready) begin
                        n.cmd   = SD_ACT;
                        n.ba    = map_ba;
                        n.a     = map_row;
                        n.r_wr  = req_write;
                        n.r_ba  = map_ba;
                        n.r_row = map_row;
                        n.r_col = map_col;
                        n.r_dat = req_wdata;
                        n.r_be  = req_be;
                        n.wt    = WAIT_W'(T_RCD - 1);
                        n.rc    = RC_W'(T_RC - 1);
                        n.st    = S_COL;
                    end
                end
                S_COL: begin
                    n.ba = q.r_ba;
                    n.a  = ROW_W'(q.r_col);
                    n.a[AP_BIT] = 1'b0;
                    if (q.r_wr) begin
                        n.cmd = SD_WR;
                        n.oe  = 1'b1;
                        n.dq  = q.r_dat;
                        n.dqm = ~q.r_be;
                        n.wt  = WAIT_W'(T_WR - 1);
                    end else begin
                        n.cmd = SD_RD;
                        n.wt  = WAIT_W'(BURST_LEN - 1);
                    end
                    n.st = S_CLOSE;
                end
                default: begin
                    n.cmd = SD_PRE;
                    n.ba  = q.r_ba;
                    n.a[AP_BIT] = 1'b0;
                    n.wt  = WAIT_W'(T_RP - 1);
                    n.st  = S_IDLE;
                end
            endcase
        end
        // interval timer: a fresh expiry wins over the clear above
        if (q.live) begin
            if (q.rcnt == '0) begin
                n.rcnt  = REF_W'(REF_CYC - 1);
                n.rpend = 1'b1;
            end else begin
                n.rcnt = q.rcnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= S_PWR;
            q.wt  <= WAIT_W'(INIT_CYC - 1);
            q.cmd <= SD_NOP;
            q.cl  <= 2'd3;
        end else begin
            q <= n;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = q.cmd;
    assign sd_ba     = q.ba;
    assign sd_addr   = q.a;
    assign sd_dqm    = q.dqm;
    assign sd_dq_out = q.dq;
    assign sd_dq_oe  = q.oe;

    sdc_rd_pipe #(.DATA_W(DATA_W), .BURST_LEN(BURST_LEN)) pipe_i (
        .clk(clk), .rst_n(rst_n), .rd_issue(q.cmd == SD_RD), .cas_lat(q.cl),
        .dq_in(sd_dq_in), .rsp_valid(rsp_valid), .rsp_data(rsp_rdata)
    );
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker
    import sdc_pkg::*;
#(
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_RC   = 9,
    parameter int T_WR   = 2,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        cmd,
    input logic [BANK_W-1:0] ba,
    input logic [ROW_W-1:0]  a,
    input logic              oe,
    input logic              req_valid,
    input logic              req_ready
);
    logic [7:0] since_act, since_pre, since_wr;
    logic [(1<<BANK_W)-1:0] open_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_act <= 8'hFF;
            since_pre <= 8'hFF;
            since_wr  <= 8'hFF;
            open_q    <= '0;
        end else begin
            since_act <= (cmd == SD_ACT) ? 8'd1 : ((since_act == 8'hFF) ? 8'hFF : since_act + 8'd1);
            since_pre <= (cmd == SD_PRE) ? 8'd1 : ((since_pre == 8'hFF) ? 8'hFF : since_pre + 8'd1);
            since_wr  <= (cmd == SD_WR)  ? 8'd1 : ((since_wr  == 8'hFF) ? 8'hFF : since_wr  + 8'd1);
            if (cmd == SD_ACT) open_q[ba] <= 1'b1;
            if (cmd == SD_PRE) begin
                if (a[AP_BIT]) open_q <= '0;
                else           open_q[ba] <= 1'b0;
            end
        end
    end

    assert_act_to_rw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == SD_RD || cmd == SD_WR) |-> (int'(since_act) >= T_RCD));
    assert_pre_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == SD_ACT || cmd == SD_REF) |-> (int'(since_pre) >= T_RP));
    assert_act_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == SD_ACT) |-> (int'(since_act) >= T_RC));
    assert_wr_recovery_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == SD_PRE) |-> (int'(since_wr) >= T_WR));
    assert_oe_with_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> (cmd == SD_WR));
    assert_ref_closed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == SD_REF) |-> (open_q == '0));
    assert_single_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

bind sdram_cmd_ctrl sdc_checker #(
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_WR(T_WR), .BANK_W(BANK_W), .ROW_W(ROW_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
    .ba(sd_ba), .a(sd_addr), .oe(sd_dq_oe), .req_valid(req_valid), .req_ready(req_ready)
);

// File: tb/sdram_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module sdram_cmd_ctrl_tb_top;
    localparam int INIT_CYC = 300;
    localparam int REF_CYC  = 400;
    localparam int T_RCD = 3, T_RP = 3, T_RC = 9, T_WR = 2;
    localparam int BL = 4;
    localparam int REF_SLACK = 48;

    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;

    logic clk = 0, rst_n = 0;
    logic [1:0] cfg_cas_lat = 2'd3;
    logic req_valid = 0, req_write = 0;
    logic [24:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0] req_be = '0;
    logic req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [1:0] sd_ba, sd_dqm;
    logic [12:0] sd_addr;
    logic [15:0] sd_dq_out;
    logic [15:0] sd_dq_in = 16'hDEAD;

    always #2.5 clk = ~clk;

    sdram_cmd_ctrl #(.INIT_CYC(INIT_CYC), .REF_CYC(REF_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cas_lat),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
        .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    int n_cmp = 0, n_bad = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] dflt(input logic [24:0] k);
        return k[15:0] ^ {7'd0, k[24:16]} ^ 16'h5A3C;
    endfunction

    function automatic logic [12:0] mode_exp(input int cl);
        return 13'({1'b1, 2'b00, 1'b0, 2'(cl), 1'b0, 3'b010});
    endfunction

    // shadow from host view; model memory from pin view
    logic [15:0] shadow [logic [24:0]];
    logic [15:0] mem    [logic [24:0]];
    logic [15:0] exp_q [$];

    int   run_cl = 3;
    int   ncyc = 0, since_rst = 0, init_idx = 0;
    int   since_act = 1000, since_pre = 1000, since_wr = 1000, since_ref = 1000;
    int   live_refs = 0, rd_neg = 0, rd_word = 0, rsp_cnt = 0, mcl = 3;
    logic [3:0]  open_b = '0;
    logic [12:0] open_row [4];
    logic [15:0] ring_d [16];
    logic        ring_v [16];

    initial for (int i = 0; i < 16; i++) ring_v[i] = 1'b0;

    // memory model and protocol monitor
    always @(negedge clk) begin
        logic [3:0] c;
        logic [24:0] k;
        ncyc++;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (!rst_n) begin
            since_rst = 0; init_idx = 0; open_b = '0; live_refs = 0;
            since_act = 1000; since_pre = 1000; since_wr = 1000; since_ref = 1000;
        end else begin
            since_rst++;
            if (since_act < 1000) since_act++;
            if (since_pre < 1000) since_pre++;
            if (since_wr < 1000) since_wr++;
            if (since_ref < 1000) since_ref++;
            if (init_idx < 5) check(req_ready == 1'b0, "R2 ready during init", req_ready, 0);
            if (c != C_NOP) begin
                if (init_idx < 5) begin
                    case (init_idx)
                        0: begin
                            check(c == C_PRE && sd_addr[10], "R2 first precharge-all", {c, sd_addr}, {C_PRE, 13'h400});
                            check(since_rst >= INIT_CYC && since_rst <= INIT_CYC + 1, "R2 init delay", since_rst, INIT_CYC);
                        end
                        1, 2: check(c == C_REF, "R2 init refresh", c, C_REF);
                        3: begin
                            check(c == C_MRS && sd_ba == 2'b00, "R2 mode load", {sd_ba, c}, {2'b00, C_MRS});
                            check(sd_addr == mode_exp(run_cl), "R3 mode word", sd_addr, mode_exp(run_cl));
                            mcl = int'(sd_addr[6:4]);
                        end
                        default: begin
                            check(c == C_MRS && sd_ba == 2'b10, "R2 ext mode load", {sd_ba, c}, {2'b10, C_MRS});
                            check(sd_addr == 13'd0, "R3 ext mode word", sd_addr, 0);
                        end
                    endcase
                    if (c == C_REF) since_ref = 0;
                    if (c == C_PRE) begin since_pre = 0; open_b = '0; end
                    init_idx++;
                end else begin
                    case (c)
                        C_ACT: begin
                            check(since_pre >= T_RP, "R6 pre to act", since_pre, T_RP);
                            check(since_act >= T_RC, "R6 act to act", since_act, T_RC);
                            check(since_ref >= T_RC, "R6 ref to act", since_ref, T_RC);
                            check(open_b == 4'd0, "R12 banks closed before act", open_b, 0);
                            open_b[sd_ba] = 1'b1; open_row[sd_ba] = sd_addr; since_act = 0;
                        end
                        C_RD, C_WR: begin
                            check(since_act >= T_RCD, "R5 act to column", since_act, T_RCD);
                            check(open_b[sd_ba], "R1 column to open bank", open_b, 1 << sd_ba);
                            if (c == C_WR) begin
                                check(sd_dq_oe, "R8 data enable on write", sd_dq_oe, 1);
                                k = {sd_ba, open_row[sd_ba], sd_addr[9:0]};
                                if (!mem.exists(k)) mem[k] = dflt(k);
                                if (!sd_dqm[0]) mem[k][7:0]  = sd_dq_out[7:0];
                                if (!sd_dqm[1]) mem[k][15:8] = sd_dq_out[15:8];
                                since_wr = 0;
                            end else begin
                                for (int i = 0; i < BL; i++) begin
                                    k = {sd_ba, open_row[sd_ba], sd_addr[9:2], 2'(sd_addr[1:0] + 2'(i))};
                                    ring_d[(ncyc + mcl + i) % 16] = mem.exists(k) ? mem[k] : dflt(k);
                                    ring_v[(ncyc + mcl + i) % 16] = 1'b1;
                                end
                                rd_neg = ncyc; rd_word = 0;
                            end
                        end
                        C_PRE: begin
                            check(since_wr >= T_WR, "R7 write to precharge", since_wr, T_WR);
                            if (sd_addr[10]) open_b = '0; else open_b[sd_ba] = 1'b0;
                            since_pre = 0;
                        end
                        C_REF: begin
                            check(open_b == 4'd0, "R11 refresh with open row", open_b, 0);
                            check(since_pre >= T_RP, "R6 pre to ref", since_pre, T_RP);
                            if (live_refs > 0)
                                check(since_ref <= REF_CYC + REF_SLACK, "R11 refresh interval", since_ref, REF_CYC);
                            live_refs++; since_ref = 0;
                        end
                        default: check(1'b0, "R4 illegal command code", c, C_NOP);
                    endcase
                end
            end
            if (c != C_WR && sd_dq_oe) check(1'b0, "R8 stray data enable", sd_dq_oe, 0);
            if (rsp_valid) begin
                rsp_cnt++;
                check(ncyc == rd_neg + run_cl + 1 + rd_word, "R10 read latency", ncyc - rd_neg, run_cl + 1 + rd_word);
                if (exp_q.size() == 0) check(1'b0, "R9 unexpected read word", rsp_rdata, 0);
                else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(rsp_rdata == e, "R9 read data", rsp_rdata, e);
                end
                rd_word++;
            end
        end
        sd_dq_in = ring_v[ncyc % 16] ? ring_d[ncyc % 16] : 16'hDEAD;
        ring_v[ncyc % 16] = 1'b0;
    end

    task automatic host_req(input bit wr, input logic [24:0] addr, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = addr; req_wdata = d; req_be = be;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        if (wr) begin
            logic [15:0] v;
            v = shadow.exists(addr) ? shadow[addr] : dflt(addr);
            if (be[0]) v[7:0]  = d[7:0];
            if (be[1]) v[15:8] = d[15:8];
            shadow[addr] = v;
        end else begin
            int base;
            base = rsp_cnt;
            for (int i = 0; i < BL; i++) begin
                logic [24:0] k;
                k = {addr[24:2], 2'(addr[1:0] + 2'(i))};
                exp_q.push_back(shadow.exists(k) ? shadow[k] : dflt(k));
            end
            for (int t = 0; t < 80 && rsp_cnt < base + BL; t++) @(negedge clk);
            repeat (2) @(negedge clk);
            check(rsp_cnt == base + BL, "R9 burst word count", rsp_cnt - base, BL);
        end
    endtask

    task automatic run_one(input logic [1:0] cfg);
        @(negedge clk);
        rst_n = 0; cfg_cas_lat = cfg;
        run_cl = (cfg == 2'd0) ? 3 : int'(cfg);
        repeat (3) @(negedge clk);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R4 reset NOP", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
        check(req_ready == 0 && rsp_valid == 0 && sd_dq_oe == 0, "R2 reset outputs", {req_ready, rsp_valid, sd_dq_oe}, 0);
        rst_n = 1;
        for (int t = 0; t < INIT_CYC + 200 && init_idx < 5; t++) @(negedge clk);
        check(init_idx == 5, "R2 init completes", init_idx, 5);
        cfg_cas_lat = cfg + 2'd1; // R10: must be ignored from here on
        host_req(1, 25'h1FFFFFF, 16'hBEEF, 2'b11);
        host_req(0, 25'h1FFFFFE, 16'h0, 2'b00);            // R9 wrap: 3FE,3FF,3FC,3FD
        host_req(1, 25'h0000005, 16'h1234, 2'b01);         // R8 low byte only
        host_req(1, 25'h0000006, 16'h5678, 2'b10);         // R8 high byte only
        host_req(1, 25'h0000007, 16'hFFFF, 2'b00);         // R8 fully masked
        host_req(0, 25'h0000005, 16'h0, 2'b00);
        host_req(1, {2'b10, 13'h1ABC, 10'h155}, 16'hA55A, 2'b11); // R1 split
        host_req(0, {2'b10, 13'h1ABC, 10'h154}, 16'h0, 2'b00);
        for (int i = 0; i < 30; i++) begin
            logic [24:0] ad;
            ad = {2'($urandom), 13'($urandom % 4), 10'($urandom % 16)};
            if ($urandom % 2) host_req(1, ad, 16'($urandom), 2'($urandom));
            else              host_req(0, ad, 16'h0, 2'b00);
        end
        repeat (REF_CYC + REF_SLACK) @(negedge clk); // idle refresh spacing, R11
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run_one(2'd1);
        run_one(2'd2);
        run_one(2'd3);
        run_one(2'd0);
        check(exp_q.size() == 0, "R9 no missing words", exp_q.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R2 actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule